// File: doc/BRIEF.md
# Windowed Threshold-Crossing Event Counter

This block sits behind a motion sensor's filtered sample path. Every sample is a signed 16-bit value that arrives with a one-cycle valid strobe. Each sample is compared against a positive upper limit and a negative lower limit. The block counts entries above the upper limit and entries below the lower limit in two separate 4-bit counters. A small state machine bounds the counting to a programmable window, measured in samples. Sticky status flags report data arrival, window expiry, a one-direction event (OR) and a two-direction event (AND). A registered interrupt line is raised from the enabled status flags.

Software reads the packed count byte with a read strobe, and the strobe also empties both counters. It clears status flags by writing a one-hot clear mask. The window machine has three states:

- `WIN_IDLE`: no window is open.
- `WIN_RUN`: a window is open and the required count has not been reached.
- `WIN_MET`: a window is open and the required count has been reached.

The machine has these transitions:

- *start*: `WIN_IDLE` to `WIN_RUN`, or to `WIN_MET` when the first crossing already satisfies the requirement. It is taken on a counted crossing while the window length is non-zero.
- *hit*: `WIN_RUN` to `WIN_MET`, on the crossing that makes the OR condition true.
- *expire*: `WIN_RUN` or `WIN_MET` to `WIN_IDLE`, on the valid sample that uses up the window.
- *read*: `WIN_RUN` or `WIN_MET` to `WIN_IDLE`, on the count read strobe.
- *restart*: an expire or read in the same cycle as a counted crossing opens a fresh window at once.

Top module: `motion_cross_counter`

## Requirements
- R1: After reset, the count byte, the status bits and the interrupt are all zero, and no window is open.
- R2: Every cycle with `smp_valid` high sets status bit 0 (data). A cycle with `smp_valid` low changes neither the counts nor the direction history.
- R3: A sample is above when it is strictly greater than `cfg_up_lvl`×128. A sample is below when it is strictly less than −(`cfg_dn_lvl`×128). A sample equal to either limit is not beyond it.
- R4: A crossing is counted only on the first valid sample beyond a limit. Later samples that stay beyond the same limit add nothing. Leaving the region and entering it again counts again.
- R5: `cnt_byte` holds the upward count in bits 7:4 and the downward count in bits 3:0. Each count saturates at 15.
- R6: A `cnt_rd` cycle zeroes both counts at the next edge. A crossing in the same cycle is counted into the emptied counters, giving a count of 1.
- R7: Status bit 3 (OR) is set on a counted crossing after which either count is at least `cfg_need`. With `cfg_need` = 0, bits 3 and 2 are never set.
- R8: Status bit 2 (AND) is set on a counted crossing after which both counts are at least `cfg_need`. Bit 3 is always set in the same cycle.
- R9: With `cfg_win` = W > 0, a window opens at the first counted crossing and expires on the W-th valid sample after it. Expiry sets status bit 1. Expiry clears both counts if the machine is still in `WIN_RUN`, and keeps them if it is in `WIN_MET`. With `cfg_win` = 0 no window ever opens.
- R10: A one in `stat_clr` clears the matching status bit at the next edge. A new event for the same bit in the same cycle wins, and the bit stays set.
- R11: `irq` goes high one edge after any status bit whose `cfg_irq_en` bit is set. It falls one edge after those bits clear. The enable bits use the status bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed sample |
| cfg_up_lvl | input | 8 | Upper limit, in steps of 128 |
| cfg_dn_lvl | input | 8 | Lower limit magnitude, in steps of 128 |
| cfg_need | input | 3 | Required crossings per direction, 0 disables events |
| cfg_win | input | 10 | Window length in valid samples, 0 disables the window |
| cfg_irq_en | input | 4 | Interrupt enable per status bit |
| cnt_rd | input | 1 | Count read strobe (clear on read) |
| stat_clr | input | 4 | Write-one-to-clear mask for status |
| cnt_byte | output | 8 | Packed counts, upward in 7:4, downward in 3:0 |
| status | output | 4 | Sticky flags: 0 data, 1 window expiry, 2 AND, 3 OR |
| irq | output | 1 | Registered interrupt level |

## Verification
The count byte and the status bits are registered, so each one reflects the inputs of a cycle exactly one rising edge later. The interrupt follows the status through one more register and is due two edges after the stimulus.

The driver applies inputs just after a falling edge. It stamps every expected item with the edge count at which it is due. The monitor compares only at the following falling edge, so no comparison races the clock.

Window-expiry cases are counted in valid samples, from the crossing that opens the window to the W-th sample after it.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;
    localparam int ST_W     = 4;
    localparam int ST_DATA  = 0;
    localparam int ST_TIMER = 1;
    localparam int ST_AND   = 2;
    localparam int ST_OR    = 3;

    localparam int N_DIR  = 2;
    localparam int DIR_UP = 0;
    localparam int DIR_DN = 1;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_RUN  = 2'd1,
        WIN_MET  = 2'd2
    } win_state_e;
endpackage

// File: rtl/mcc_cross_detect.sv
`timescale 1ns/1ps
module mcc_cross_detect
    import mcc_pkg::*;
#(
    parameter int SMP_W     = 16,
    parameter int LVL_W     = 8,
    parameter int LVL_SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [LVL_W-1:0] cfg_up_lvl,
    input  logic [LVL_W-1:0] cfg_dn_lvl,
    output logic [N_DIR-1:0] enter
);
    localparam int MAG_W = LVL_W + LVL_SHIFT;
    localparam int XW    = ((SMP_W > MAG_W) ? SMP_W : MAG_W) + 2;

    logic signed [XW-1:0] smp_x;
    logic signed [XW-1:0] up_x;
    logic signed [XW-1:0] dn_x;
    logic [N_DIR-1:0]     beyond;
    logic [N_DIR-1:0]     beyond_q;

    // R3: strict comparison against scaled limits
    always_comb begin
        smp_x          = XW'($signed(smp_data));
        up_x           = XW'({cfg_up_lvl, {LVL_SHIFT{1'b0}}});
        dn_x           = -XW'({cfg_dn_lvl, {LVL_SHIFT{1'b0}}});
        beyond         = '0;
        beyond[DIR_UP] = (smp_x > up_x);
        beyond[DIR_DN] = (smp_x < dn_x);
    end

    // R2/R4: history advances on valid samples only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beyond_q <= '0;
        end else if (smp_valid) begin
            beyond_q <= beyond;
        end
    end

    assign enter = smp_valid ? (beyond & ~beyond_q) : '0;
endmodule

// File: rtl/mcc_sat_count.sv
`timescale 1ns/1ps
module mcc_sat_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] q,
    output logic [CNT_W-1:0] nxt
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] base;

    // R5 saturation, R6 clear-then-count
    always_comb begin
        base = clr ? '0 : q;
        nxt  = (inc && (base != CNT_TOP)) ? base + CNT_W'(1) : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/mcc_window_fsm.sv
`timescale 1ns/1ps
module mcc_window_fsm
    import mcc_pkg::*;
#(
    parameter int WIN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             cross_any,
    input  logic             or_hit,
    input  logic             cnt_rd,
    input  logic [WIN_W-1:0] cfg_win,
    output win_state_e       state,
    output logic             expire,
    output logic             clr_cnt
);
    win_state_e       state_n;
    logic [WIN_W-1:0] tmr_q;
    logic [WIN_W-1:0] tmr_n;
    logic             leave;
    logic             win_on;

    assign win_on = (cfg_win != '0);
    assign leave  = cnt_rd | expire;

    // next state and timer
    always_comb begin
        state_n = state;
        tmr_n   = tmr_q;
        unique case (state)
            WIN_IDLE: begin
                state_n = WIN_IDLE;
            end
            WIN_RUN: begin
                if (leave) begin
                    state_n = WIN_IDLE;
                end else begin
                    if (smp_valid) tmr_n = tmr_q - WIN_W'(1);
                    if (or_hit)    state_n = WIN_MET;
                end
            end
            WIN_MET: begin
                if (leave) begin
                    state_n = WIN_IDLE;
                end else if (smp_valid) begin
                    tmr_n = tmr_q - WIN_W'(1);
                end
            end
            default: begin
                state_n = WIN_IDLE;
            end
        endcase
        // start / restart
        if ((state_n == WIN_IDLE) && cross_any && win_on) begin
            state_n = or_hit ? WIN_MET : WIN_RUN;
            tmr_n   = cfg_win;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WIN_IDLE;
            tmr_q <= '0;
        end else begin
            state <= state_n;
            tmr_q <= tmr_n;
        end
    end

    // outputs: R9 expiry, R6/R9 count clear
    always_comb begin
        expire  = (state != WIN_IDLE) && smp_valid && (tmr_q == WIN_W'(1));
        clr_cnt = cnt_rd || (expire && (state == WIN_RUN));
    end
endmodule

// File: rtl/mcc_status_irq.sv
`timescale 1ns/1ps
module mcc_status_irq
    import mcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set,
    input  logic [ST_W-1:0] clr,
    input  logic [ST_W-1:0] en,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    // R10: per-bit sticky flag, set wins over clear
    for (genvar b = 0; b < ST_W; b++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= set[b] | (flag_q & ~clr[b]);
            end
        end
        assign status[b] = flag_q;
    end

    // R11: registered interrupt level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |(status & en);
        end
    end
endmodule

// File: rtl/motion_cross_counter.sv
`timescale 1ns/1ps
module motion_cross_counter
    import mcc_pkg::*;
#(
    parameter int SMP_W     = 16,
    parameter int LVL_W     = 8,
    parameter int LVL_SHIFT = 7,
    parameter int CNT_W     = 4,
    parameter int NEED_W    = 3,
    parameter int WIN_W     = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [SMP_W-1:0]     smp_data,
    input  logic [LVL_W-1:0]     cfg_up_lvl,
    input  logic [LVL_W-1:0]     cfg_dn_lvl,
    input  logic [NEED_W-1:0]    cfg_need,
    input  logic [WIN_W-1:0]     cfg_win,
    input  logic [ST_W-1:0]      cfg_irq_en,
    input  logic                 cnt_rd,
    input  logic [ST_W-1:0]      stat_clr,
    output logic [2*CNT_W-1:0]   cnt_byte,
    output logic [ST_W-1:0]      status,
    output logic                 irq
);
    logic [N_DIR-1:0] enter;
    logic [CNT_W-1:0] cnt_q   [N_DIR];
    logic [CNT_W-1:0] cnt_nxt [N_DIR];
    logic [N_DIR-1:0] reach;
    logic             cross_any;
    logic             need_on;
    logic             or_hit;
    logic             and_hit;
    logic             clr_cnt;
    logic             win_expire;
    win_state_e       win_state;
    logic [ST_W-1:0]  st_set;

    mcc_cross_detect #(
        .SMP_W     (SMP_W),
        .LVL_W     (LVL_W),
        .LVL_SHIFT (LVL_SHIFT)
    ) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .cfg_up_lvl (cfg_up_lvl),
        .cfg_dn_lvl (cfg_dn_lvl),
        .enter      (enter)
    );

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        mcc_sat_count #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_cnt),
            .inc   (enter[d]),
            .q     (cnt_q[d]),
            .nxt   (cnt_nxt[d])
        );
        assign reach[d] = (cnt_nxt[d] >= CNT_W'(cfg_need));
    end

    // R7/R8: events evaluated on the post-update counts
    always_comb begin
        cross_any = |enter;
        need_on   = (cfg_need != '0);
        or_hit    = cross_any && need_on && (|reach);
        and_hit   = cross_any && need_on && (&reach);
    end

    mcc_window_fsm #(.WIN_W(WIN_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .cross_any (cross_any),
        .or_hit    (or_hit),
        .cnt_rd    (cnt_rd),
        .cfg_win   (cfg_win),
        .state     (win_state),
        .expire    (win_expire),
        .clr_cnt   (clr_cnt)
    );

    always_comb begin
        st_set           = '0;
        st_set[ST_DATA]  = smp_valid;
        st_set[ST_TIMER] = win_expire;
        st_set[ST_AND]   = and_hit;
        st_set[ST_OR]    = or_hit;
    end

    mcc_status_irq u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (st_set),
        .clr    (stat_clr),
        .en     (cfg_irq_en),
        .status (status),
        .irq    (irq)
    );

    // R5: upward nibble high, downward nibble low
    assign cnt_byte = {cnt_q[DIR_UP], cnt_q[DIR_DN]};
endmodule

// File: rtl/mcc_checker.sv
`timescale 1ns/1ps
module mcc_checker
    import mcc_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int NEED_W = 3,
    parameter int WIN_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_valid,
    input logic               cnt_rd,
    input logic [ST_W-1:0]    stat_clr,
    input logic [NEED_W-1:0]  cfg_need,
    input logic [WIN_W-1:0]   cfg_win,
    input logic [ST_W-1:0]    cfg_irq_en,
    input logic [2*CNT_W-1:0] cnt_byte,
    input logic [ST_W-1:0]    status,
    input logic               irq,
    input win_state_e         win_state,
    input logic               expire
);
    logic [CNT_W-1:0] up_n;
    logic [CNT_W-1:0] dn_n;
    assign up_n = cnt_byte[2*CNT_W-1:CNT_W];
    assign dn_n = cnt_byte[CNT_W-1:0];

    p_data_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> status[ST_DATA]);

    p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_rd && !expire) |=> ((up_n == $past(up_n)) || (up_n == $past(up_n) + CNT_W'(1))));

    p_dn_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_rd && !expire) |=> ((dn_n == $past(dn_n)) || (dn_n == $past(dn_n) + CNT_W'(1))));

    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((up_n == '1) && !cnt_rd && !expire) |=> (up_n == '1));

    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && !smp_valid) |=> (cnt_byte == '0));

    p_need_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_need == '0) |=> !$rose(status[ST_OR]));

    p_and_with_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_AND]) |-> status[ST_OR]);

    p_expire_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status[ST_TIMER]);

    p_no_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_win == '0) && (win_state == WIN_IDLE)) |=> (win_state == WIN_IDLE));

    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr[ST_TIMER] && !expire) |=> !status[ST_TIMER]);

    p_irq_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cfg_irq_en != '0));
endmodule

bind motion_cross_counter mcc_checker #(
    .CNT_W  (CNT_W),
    .NEED_W (NEED_W),
    .WIN_W  (WIN_W)
) u_mcc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .cnt_rd     (cnt_rd),
    .stat_clr   (stat_clr),
    .cfg_need   (cfg_need),
    .cfg_win    (cfg_win),
    .cfg_irq_en (cfg_irq_en),
    .cnt_byte   (cnt_byte),
    .status     (status),
    .irq        (irq),
    .win_state  (win_state),
    .expire     (win_expire)
);

// File: tb/tb_motion_cross_counter.sv
`timescale 1ns/1ps
module tb_motion_cross_counter;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [7:0]  cfg_up_lvl = 8'd4;
    logic [7:0]  cfg_dn_lvl = 8'd2;
    logic [2:0]  cfg_need = 3'd0;
    logic [9:0]  cfg_win = 10'd0;
    logic [3:0]  cfg_irq_en = 4'd0;
    logic        cnt_rd = 1'b0;
    logic [3:0]  stat_clr = 4'd0;
    logic [7:0]  cnt_byte;
    logic [3:0]  status;
    logic        irq;

    motion_cross_counter dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .cfg_up_lvl (cfg_up_lvl),
        .cfg_dn_lvl (cfg_dn_lvl),
        .cfg_need   (cfg_need),
        .cfg_win    (cfg_win),
        .cfg_irq_en (cfg_irq_en),
        .cnt_rd     (cnt_rd),
        .stat_clr   (stat_clr),
        .cnt_byte   (cnt_byte),
        .status     (status),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int         due;
        int         kind;   // 0 count byte, 1 status, 2 irq
        logic [7:0] val;
        string      req;
    } item_t;

    item_t sb[$];
    int    cyc    = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare items due at this edge, half a period after it
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [7:0] act;
                case (sb[i].kind)
                    0:       act = cnt_byte;
                    1:       act = {4'b0, status};
                    default: act = {7'b0, irq};
                endcase
                checks++;
                if (act !== sb[i].val) begin
                    errors++;
                    $display("FAIL %s %s actual=%h expected=%h", sb[i].req,
                             (sb[i].kind == 0) ? "cnt_byte" : (sb[i].kind == 1) ? "status" : "irq",
                             act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic push(input int kind, input logic [7:0] v, input string req, input int lat);
        item_t it;
        it.due  = cyc + lat;
        it.kind = kind;
        it.val  = v;
        it.req  = req;
        sb.push_back(it);
    endtask

    // driver: apply one cycle of stimulus and queue the expected outputs
    task automatic run(input bit v, input int d, input bit rd, input logic [3:0] clr,
                       input logic [7:0] ecnt, input logic [3:0] est, input string req);
        smp_valid = v;
        smp_data  = d[15:0];
        cnt_rd    = rd;
        stat_clr  = clr;
        push(0, ecnt, req, 1);
        push(1, {4'b0, est}, req, 1);
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        cnt_rd    = 1'b0;
        stat_clr  = 4'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        push(2, 8'h00, "R1", 1);
        run(0, 0, 0, 4'h0, 8'h00, 4'h0, "R1");

        // thresholds: up limit 512, down limit -256; R3, R4, R5, R2
        run(1, 512,  0, 4'h0, 8'h00, 4'h1, "R3 equal upper");
        run(1, 513,  0, 4'h0, 8'h10, 4'h1, "R3 above upper");
        run(1, 600,  0, 4'h0, 8'h10, 4'h1, "R4 stays above");
        run(1, 0,    0, 4'h0, 8'h10, 4'h1, "R4 back inside");
        run(1, -256, 0, 4'h0, 8'h10, 4'h1, "R3 equal lower");
        run(1, -257, 0, 4'h0, 8'h11, 4'h1, "R5 nibble layout");
        run(0, 1000, 0, 4'h0, 8'h11, 4'h1, "R2 invalid ignored");
        run(1, 700,  0, 4'h0, 8'h21, 4'h1, "R4 re-entry counts");
        run(0, 0,    0, 4'hF, 8'h21, 4'h0, "R10 clear all");
        run(0, 0,    0, 4'h0, 8'h21, 4'h0, "R2 no data flag");
        // R6 read clear, and read with a crossing in the same cycle
        run(0, 0,    1, 4'h0, 8'h00, 4'h0, "R6 read clears");
        run(1, -300, 1, 4'h0, 8'h01, 4'h1, "R6 read with crossing / R7 need zero");

        // R5 saturation
        run(0, 0, 1, 4'h0, 8'h00, 4'h1, "R6 read");
        for (int i = 0; i < 17; i++) begin
            run(1, 600, 0, 4'h0, {((i + 1) > 15) ? 4'hF : 4'(i + 1), 4'h0}, 4'h1, "R5 saturation");
            run(1, 0,   0, 4'h0, {((i + 1) > 15) ? 4'hF : 4'(i + 1), 4'h0}, 4'h1, "R5 saturation");
        end

        // R7, R8, R10, R11 with need 2 and a long window
        cfg_need = 3'd2;
        cfg_win  = 10'd1000;
        run(0, 0,    1, 4'hF, 8'h00, 4'h0, "R6 read");
        run(1, 600,  0, 4'h0, 8'h10, 4'h1, "R7 below need");
        run(1, 0,    0, 4'h0, 8'h10, 4'h1, "R7");
        run(1, 600,  0, 4'h0, 8'h20, 4'h9, "R7 OR event");
        run(1, -300, 0, 4'h0, 8'h21, 4'h9, "R8 one side only");
        run(1, 0,    0, 4'h0, 8'h21, 4'h9, "R8");
        push(2, 8'h00, "R11 disabled", 1);
        run(1, -300, 0, 4'h0, 8'h22, 4'hD, "R8 AND event");
        cfg_irq_en = 4'h8;
        push(2, 8'h01, "R11 irq rises", 1);
        run(0, 0,    0, 4'h0, 8'h22, 4'hD, "R11");
        push(2, 8'h01, "R11 irq lags clear", 1);
        push(2, 8'h00, "R11 irq falls", 2);
        run(0, 0,    0, 4'hC, 8'h22, 4'h1, "R10 clear events");
        run(0, 0,    0, 4'h0, 8'h22, 4'h1, "R11");
        run(1, 600,  0, 4'h8, 8'h32, 4'hD, "R10 set wins");
        cfg_irq_en = 4'h0;
        run(0, 0,    1, 4'hF, 8'h00, 4'h0, "R6 read");

        // R9 window of 4 samples, need 3: expiry clears counts
        cfg_need = 3'd3;
        cfg_win  = 10'd4;
        run(1, 0,   0, 4'hF, 8'h00, 4'h1, "R9");
        run(1, 600, 0, 4'h0, 8'h10, 4'h1, "R9 window opens");
        run(1, 0,   0, 4'h0, 8'h10, 4'h1, "R9");
        run(1, 600, 0, 4'h0, 8'h20, 4'h1, "R9");
        run(1, 0,   0, 4'h0, 8'h20, 4'h1, "R9 before expiry");
        run(1, 0,   0, 4'h0, 8'h00, 4'h3, "R9 expiry clears counts");
        run(0, 0,   0, 4'h2, 8'h00, 4'h1, "R10 clear timer flag");
        // need met before expiry: counts kept
        cfg_need = 3'd2;
        run(1, 600, 0, 4'h0, 8'h10, 4'h1, "R9 window opens");
        run(1, 0,   0, 4'h0, 8'h10, 4'h1, "R9");
        run(1, 600, 0, 4'h0, 8'h20, 4'h9, "R9 need met");
        run(1, 0,   0, 4'h0, 8'h20, 4'h9, "R9");
        run(1, 0,   0, 4'h0, 8'h20, 4'hB, "R9 expiry keeps counts");
        // window length zero: no timer
        cfg_need = 3'd0;
        cfg_win  = 10'd0;
        run(0, 0, 1, 4'hF, 8'h00, 4'h0, "R6 read");
        for (int i = 0; i < 3; i++) begin
            run(1, 600, 0, 4'h0, {4'(i + 1), 4'h0}, 4'h1, "R9 no window");
            run(1, 0,   0, 4'h0, {4'(i + 1), 4'h0}, 4'h1, "R9 no window");
        end

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items actual=%0d expected=0", sb.size(), sb.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule